// File: doc/BRIEF.md
# Sine-Table Bridge Gate Pulse Generator

This block drives the two switching channels of a single-phase full-bridge inverter. It uses unipolar sinusoidal pulse-width modulation built from a fixed table of pulse widths. Time is split into switching slots of equal length. Each slot holds one left-aligned pulse, and its width is read from a built-in 19-value sine-shaped sequence.

One half of the output cycle is made of 19 pulse slots and then one idle slot. Channel 1 supplies the first half and channel 2 supplies the second. The two halves then repeat without end. A half-cycle indicator shows which channel currently owns the bridge.

A prescaler divides the system clock into sub-ticks, and each slot is a fixed number of sub-ticks long. With a 50 MHz clock, a divide-by-500 prescaler gives a 10 µs sub-tick. Fifty sub-ticks then make a 500 µs slot, which is a 2 kHz switching rate. Forty slots make a 20 ms output period, which is 50 Hz.

Top module: `spwm_bridge_gen`

## Requirements
- R1: A sub-tick lasts PRESCALE enabled clock cycles, and a slot lasts SLOT_TICKS sub-ticks (default 50). With en held high, every slot therefore spans PRESCALE*SLOT_TICKS clock cycles.
- R2: A half-cycle is 20 slots: slot indices 0..18 are pulse slots and index 19 is the idle slot. half_sel inverts at the clock edge that ends the idle slot and changes at no other time.
- R3: In pulse slot k, the owning channel is high while the sub-tick count within the slot is below duty(k), and low for the rest of the slot. The duty values for k = 0..18 are 6, 9, 14, 18, 21, 25, 27, 29, 30, 30, 30, 29, 27, 25, 21, 18, 14, 9, 6.
- R4: Both channels are low for the whole idle slot.
- R5: ch1_out may be high only while half_sel is 0, and ch2_out only while half_sel is 1. The channel that does not own the bridge stays low for its whole half-cycle.
- R6: ch1_out and ch2_out are never high at the same time.
- R7: Synchronous reset drives both channels low and sets half_sel to 0. After reset, the block restarts at sub-tick 0 of slot 0 with channel 1 owning the bridge.
- R8: At a clock edge where en is sampled low, all counters hold their values and both channels go low. When en returns high, the sequence resumes from the point where it stopped.
- R9: Starting from reset with en held high, one full output cycle of 40 slots has exactly 19 pulses on each channel, and half_sel returns to 0 at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, counters freeze and outputs are forced low |
| ch1_out | output | 1 | Gate drive for the first half-cycle (registered) |
| ch2_out | output | 1 | Gate drive for the second half-cycle (registered) |
| half_sel | output | 1 | 0 while channel 1 owns the bridge, 1 while channel 2 does |

## Verification
The hardest states to reach from the ports are enable gaps that land on the slot boundary, on the idle slot or on the half-cycle wrap. In those states a bad freeze or resume would show up only as a shifted or corrupted later pulse. To reach them, the bench runs the block with a small prescaler. It applies a periodic enable gap whose period is coprime with the slot length, so over several cycles the gaps drift across every slot position. A cycle-exact arithmetic model checks every output after every edge. A reset is also asserted in the middle of a half-cycle to confirm that the restart returns to slot 0 of channel 1.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int PULSE_SLOTS = 19;
  localparam int DUTY_W      = 8;

  function automatic logic [DUTY_W-1:0] duty_of(input logic [4:0] k);
    logic [DUTY_W-1:0] d;
    case (k)
      5'd0,  5'd18: d = 8'h06;
      5'd1,  5'd17: d = 8'h09;
      5'd2,  5'd16: d = 8'h0E;
      5'd3,  5'd15: d = 8'h12;
      5'd4,  5'd14: d = 8'h15;
      5'd5,  5'd13: d = 8'h19;
      5'd6,  5'd12: d = 8'h1B;
      5'd7,  5'd11: d = 8'h1D;
      5'd8,  5'd9, 5'd10: d = 8'h1E;
      default: d = 8'h00;
    endcase
    return d;
  endfunction

  function automatic logic pulse_high(input logic [4:0] k, input int unsigned tick_in_slot);
    return (k < 5'(PULSE_SLOTS)) && (tick_in_slot < 32'(duty_of(k)));
  endfunction
endpackage

// File: rtl/spwm_prescaler.sv
module spwm_prescaler #(
  parameter int DIV = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spwm_slot_timer.sv
module spwm_slot_timer #(
  parameter int SLOT_TICKS = 50,
  parameter int SUB_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [SUB_W-1:0] sub_cnt,
  output logic [4:0]       slot_idx,
  output logic             half,
  output logic             slot_idle,
  output logic             half_wrap
);
  import spwm_pkg::*;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOT_TICKS - 1);
  localparam logic [4:0]       IDLE_IDX = 5'(PULSE_SLOTS);

  logic slot_end;

  assign slot_end  = tick && (sub_cnt == SUB_LAST);
  assign slot_idle = (slot_idx == IDLE_IDX);
  assign half_wrap = slot_end && slot_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt  <= '0;
      slot_idx <= '0;
      half     <= 1'b0;
    end else if (tick) begin
      if (slot_end) begin
        sub_cnt <= '0;
        if (slot_idle) begin
          slot_idx <= '0;
          half     <= ~half;
        end else begin
          slot_idx <= slot_idx + 1'b1;
        end
      end else begin
        sub_cnt <= sub_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spwm_pulse_out.sv
module spwm_pulse_out #(
  parameter int SUB_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SUB_W-1:0] sub_cnt,
  input  logic [4:0]       slot_idx,
  input  logic             half,
  output logic             ch1,
  output logic             ch2
);
  import spwm_pkg::*;
  logic active;

  assign active = en && pulse_high(slot_idx, 32'(sub_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      ch1 <= 1'b0;
      ch2 <= 1'b0;
    end else begin
      ch1 <= active && !half;
      ch2 <= active && half;
    end
  end
endmodule

// File: rtl/spwm_bridge_gen.sv
module spwm_bridge_gen #(
  parameter int PRESCALE   = 500,
  parameter int SLOT_TICKS = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ch1_out,
  output logic ch2_out,
  output logic half_sel
);
  localparam int SUB_W = $clog2(SLOT_TICKS);

  logic             tick;
  logic [SUB_W-1:0] sub_cnt;
  logic [4:0]       slot_idx;
  logic             slot_idle;
  logic             half_wrap;

  spwm_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .en(en), .tick(tick)
  );

  spwm_slot_timer #(.SLOT_TICKS(SLOT_TICKS), .SUB_W(SUB_W)) u_slot (
    .clk(clk), .rst(rst), .tick(tick), .sub_cnt(sub_cnt), .slot_idx(slot_idx),
    .half(half_sel), .slot_idle(slot_idle), .half_wrap(half_wrap)
  );

  spwm_pulse_out #(.SUB_W(SUB_W)) u_out (
    .clk(clk), .rst(rst), .en(en), .sub_cnt(sub_cnt), .slot_idx(slot_idx),
    .half(half_sel), .ch1(ch1_out), .ch2(ch2_out)
  );
endmodule

// File: rtl/spwm_bridge_chk.sv
module spwm_bridge_chk #(
  parameter int SUB_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             tick,
  input logic [SUB_W-1:0] sub_cnt,
  input logic             slot_idle,
  input logic             half_wrap,
  input logic             ch1_out,
  input logic             ch2_out,
  input logic             half_sel
);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ch1_out && ch2_out));

  a_r5_owner: assert property (@(posedge clk) disable iff (rst)
    (ch1_out |-> !half_sel) and (ch2_out |-> half_sel));

  a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
    $past(slot_idle) |-> (!ch1_out && !ch2_out));

  a_r8_disable_low: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!ch1_out && !ch2_out));

  a_r2_half_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$stable(half_sel) && !$past(rst)) |-> $past(half_wrap));

  a_r1_sub_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(tick) && !$past(rst)) |-> $stable(sub_cnt));
endmodule

bind spwm_bridge_gen spwm_bridge_chk #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick), .sub_cnt(sub_cnt),
  .slot_idle(slot_idle), .half_wrap(half_wrap),
  .ch1_out(ch1_out), .ch2_out(ch2_out), .half_sel(half_sel)
);

// File: tb/spwm_bridge_gen_tb.sv
module spwm_bridge_gen_tb;
  localparam int P  = 2;
  localparam int ST = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic ch1_out, ch2_out, half_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_pc, m_sub, m_slot, m_half;
  int rise1, rise2;
  logic prev1, prev2;

  always #10 clk = ~clk;

  spwm_bridge_gen #(.PRESCALE(P), .SLOT_TICKS(ST)) u_dut (
    .clk(clk), .rst(rst), .en(en),
    .ch1_out(ch1_out), .ch2_out(ch2_out), .half_sel(half_sel)
  );

  function automatic int bduty(int s);
    int half_tab [10] = '{6, 9, 14, 18, 21, 25, 27, 29, 30, 30};
    if (s > 18) return 0;
    return half_tab[(s <= 9) ? s : 18 - s];
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_sub = 0; m_slot = 0; m_half = 0;
  endtask

  // One clock: drive at negedge, predict, step, compare at next negedge.
  task automatic step(bit r, bit e);
    int e1, e2;
    string tag;
    rst = r; en = e;
    if (r) begin
      e1 = 0; e2 = 0; model_reset();
      tag = "R7";
    end else begin
      e1 = (e && m_half == 0 && m_sub < bduty(m_slot)) ? 1 : 0;
      e2 = (e && m_half == 1 && m_sub < bduty(m_slot)) ? 1 : 0;
      tag = !e ? "R8" : (m_slot == 19) ? "R4" : (m_half == 0) ? "R3/R5 ch1" : "R3/R5 ch2";
      if (e) begin
        if (m_pc == P - 1) begin
          m_pc = 0;
          if (m_sub == ST - 1) begin
            m_sub = 0;
            if (m_slot == 19) begin m_slot = 0; m_half ^= 1; end
            else m_slot++;
          end else m_sub++;
        end else m_pc++;
      end
    end
    @(negedge clk);
    check({tag, " ch1"}, int'(ch1_out), e1);
    check({tag, " ch2"}, int'(ch2_out), e2);
    check("R2 half_sel", int'(half_sel), m_half);
    if (ch1_out && ch2_out) check("R6 overlap", 1, 0);
    if (ch1_out && !prev1) rise1++;
    if (ch2_out && !prev2) rise2++;
    prev1 = ch1_out; prev2 = ch2_out;
  endtask

  initial begin
    model_reset();
    prev1 = 0; prev2 = 0; rise1 = 0; rise2 = 0;
    @(negedge clk);
    step(1, 0);
    step(1, 0);
    check("R7 reset ch1", int'(ch1_out), 0);
    check("R7 reset ch2", int'(ch2_out), 0);
    check("R7 reset half", int'(half_sel), 0);

    // R9/R1: one full output cycle, enable held high
    rise1 = 0; rise2 = 0;
    for (int i = 0; i < 40 * ST * P; i++) begin
      step(0, 1);
      if (i == 20 * ST * P - 2) check("R1 half still 0 before wrap", int'(half_sel), 0);
      if (i == 20 * ST * P - 1) check("R1 half flips after 20 slots", int'(half_sel), 1);
    end
    check("R9 ch1 pulses per cycle", rise1, 19);
    check("R9 ch2 pulses per cycle", rise2, 19);
    check("R9 half back to 0", int'(half_sel), 0);

    // R8: enable gaps drifting across slot positions
    for (int i = 0; i < 9000; i++) step(0, (i % 233) >= 17);

    // R7: reset mid half-cycle, then restart from slot 0 of channel 1
    for (int i = 0; i < 1111; i++) step(0, 1);
    step(1, 1);
    rise1 = 0; rise2 = 0;
    for (int i = 0; i < 20 * ST * P; i++) step(0, 1);
    check("R7 ch1 pulses after restart", rise1, 19);
    check("R7 ch2 silent in first half", rise2, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule